// File: doc/BRIEF.md
# SDR SDRAM Bank Command Timing Engine

This block sits between a simple request port and a four-bank single-data-rate SDRAM. Each request names a bank, a row and a column, says whether it is a read or a write, and carries a byte mask. The engine keeps the open row of every bank. A request whose row is already open goes straight to a column command. A request to a closed bank first opens the row. A request to a different row first closes the bank, then opens the new row. Per-bank down-counters hold off every command until the spacing rules of the memory are met.

On every read the engine raises a capture strobe in the clock cycle in which data is valid at the pins. That cycle is two or three clocks after the read command, as selected by the latency input. The engine also places the read mask two clocks ahead of the data, and the write mask in the same cycle as the write command. A refresh request from outside stops new requests. The engine lets the request already accepted finish, closes all banks with one all-bank precharge, and then grants the refresh. A bank left open for too long is closed automatically.

All command, bank, address, mask and drive-enable outputs come from registers. A command chosen in one cycle therefore appears at the pins in the next cycle. All timing below is counted in cycles at the pins.

Top module: `sdr_bank_engine`

## Requirements
- R1: After reset the pins show NOP ({cs_n,ras_n,cas_n,we_n}=0111). `sd_wr_oe`, `rd_capture`, `ref_grant` and `sd_dqm` are 0, and `req_ready` is 1 while `ref_req` is 0.
- R2: A request to a closed bank gives ACTIVE (0011), with the row on `sd_addr` and the bank on `sd_ba`. Its column command follows exactly T_RCD=3 cycles later when nothing else blocks it. A column command carries the column on `sd_addr[9:0]` with `sd_addr[10]`=0; READ is 0101 and WRITE is 0100.
- R3: A request that hits the open row of its bank gives only a column command, with no ACTIVE. Requests to open rows offered back to back give column commands in consecutive cycles.
- R4: A request to a different row of an open bank gives PRECHARGE (0010, `sd_addr[10]`=0) to that bank. ACTIVE of the new row follows exactly T_RP=3 cycles later, and the column command T_RCD cycles after that, when no other limit binds.
- R5: A bank is precharged no sooner than T_RAS=6 cycles after its ACTIVE. With no other limit, a row miss right after an activate precharges exactly 6 cycles after that ACTIVE.
- R6: Two ACTIVE commands to one bank are at least T_RC=8 cycles apart.
- R7: ACTIVE commands to different banks are at least T_RRD=2 cycles apart.
- R8: A bank is precharged no sooner than T_WR=2 cycles after a WRITE to it. A WRITE followed by a row miss in the same bank gives PRECHARGE at WRITE+2, ACTIVE at WRITE+5 and the column command at WRITE+8.
- R9: `rd_capture` is high for one cycle exactly CL cycles after each READ. CL is 2 when `cas_lat3`=0 and 3 when `cas_lat3`=1.
- R10: `sd_dqm` carries the request's mask (1 = byte masked). For a write it appears in the WRITE cycle. For a read it appears CL-2 cycles after the READ: in the same cycle for CL 2, one cycle later for CL 3. Otherwise `sd_dqm` is 0.
- R11: `sd_wr_oe` is high exactly in the cycles that carry WRITE.
- R12: While `ref_req` is 1, `req_ready` is 0. Once the accepted request has issued its column command, the engine issues one PRECHARGE with `sd_addr[10]`=1, as soon as every open bank meets R5 and R8. `ref_grant` rises exactly T_RP cycles after that PRECHARGE. While granted only NOP is issued, and after the refresh every bank is closed.
- R13: A bank left open without a row miss is precharged exactly T_RAS_LIM=12400 cycles after its ACTIVE, with `sd_addr[10]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | 1 selects read latency 3, 0 selects 2 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on a clock with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_mask | input | 9 | Byte mask for the access, 1 = masked |
| ref_req | input | 1 | Refresh wanted; held until the refresh is done |
| ref_grant | output | 1 | All banks closed and precharged; refresh may run |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row / column address |
| sd_dqm | output | 9 | Data mask |
| sd_wr_oe | output | 1 | Drive write data this cycle |
| rd_capture | output | 1 | Read data valid at the pins this cycle |

## Verification
The bench measures cycle distances between commands at the pins for a closed bank, a row hit, a row miss right after a write and a row miss right after an activate. An engine that counted a limit from the wrong register stage would shift those distances by a cycle. It would also issue a column command too early, or precharge before the write had settled. Read capture and read masking are checked at both latencies, since a design that ignored the latency select would strobe or mask the wrong data beat. The bench also checks refresh and row aging. Refresh must close every bank with a single all-bank precharge and grant only after the precharge time. Row aging must close an idle bank at exactly the age limit, and a missing aging path would leave it open forever.

// File: rtl/sdr_eng_pkg.sv
package sdr_eng_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } sdr_cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(sdr_cmd_e c);
    case (c)
      CMD_ACT: return 4'b0011;
      CMD_RD:  return 4'b0101;
      CMD_WR:  return 4'b0100;
      CMD_PRE: return 4'b0010;
      default: return 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer #(
  parameter int ROW_W     = 13,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 8,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_RAS_LIM = 12400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_pre,
  input  logic             do_wr,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             act_ok,
  output logic             rp_ok,
  output logic             ras_due
);
  localparam int SMAX = T_RCD + T_RAS + T_RC + T_RP + T_WR;
  localparam int SW   = $clog2(SMAX + 1);
  localparam int LW   = $clog2(T_RAS_LIM + 1);

  logic [SW-1:0] rcd_q, rcd_n, ras_q, ras_n, rc_q, rc_n, rp_q, rp_n, wr_q, wr_n;
  logic [LW-1:0] lim_q, lim_n;
  logic          open_q, open_n;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    rcd_n  = (rcd_q != '0) ? rcd_q - SW'(1) : rcd_q;
    ras_n  = (ras_q != '0) ? ras_q - SW'(1) : ras_q;
    rc_n   = (rc_q  != '0) ? rc_q  - SW'(1) : rc_q;
    rp_n   = (rp_q  != '0) ? rp_q  - SW'(1) : rp_q;
    wr_n   = (wr_q  != '0) ? wr_q  - SW'(1) : wr_q;
    lim_n  = (lim_q != '0) ? lim_q - LW'(1) : lim_q;
    open_n = open_q;
    if (do_act) begin
      rcd_n  = SW'(T_RCD - 1);
      ras_n  = SW'(T_RAS - 1);
      rc_n   = SW'(T_RC - 1);
      lim_n  = LW'(T_RAS_LIM - 1);
      open_n = 1'b1;
    end
    if (do_pre) begin
      rp_n   = SW'(T_RP - 1);
      open_n = 1'b0;
    end
    if (do_wr) wr_n = SW'(T_WR - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcd_q  <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
      lim_q  <= '0;
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      rcd_q  <= rcd_n;
      ras_q  <= ras_n;
      rc_q   <= rc_n;
      rp_q   <= rp_n;
      wr_q   <= wr_n;
      lim_q  <= lim_n;
      open_q <= open_n;
      if (do_act) row_q <= act_row;
    end
  end

  assign is_open  = open_q;
  assign open_row = row_q;
  assign col_ok   = open_q && (rcd_q == '0);
  assign pre_ok   = open_q && (ras_q == '0) && (wr_q == '0);
  assign rp_ok    = (rp_q == '0);
  assign act_ok   = !open_q && rp_ok && (rc_q == '0);
  assign ras_due  = open_q && (lim_q == '0);

endmodule

// File: rtl/sdr_rd_align.sv
module sdr_rd_align #(
  parameter int DQM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_lat3,
  input  logic             rd_now,
  input  logic [DQM_W-1:0] rd_mask,
  output logic             capture,
  output logic [DQM_W-1:0] rd_dqm
);
  logic [2:0]       pipe_q;
  logic [DQM_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      mask_q <= '0;
    end else begin
      pipe_q <= {pipe_q[1:0], rd_now};
      mask_q <= rd_now ? rd_mask : '0;
    end
  end

  // data is at the pins CL cycles after READ; mask leads data by two cycles
  assign capture = cas_lat3 ? pipe_q[2] : pipe_q[1];
  assign rd_dqm  = cas_lat3 ? mask_q : (rd_now ? rd_mask : '0);

endmodule

// File: rtl/sdr_bank_engine.sv
module sdr_bank_engine
  import sdr_eng_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BA_W      = 2,
  parameter int DQM_W     = 9,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 8,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_RAS_LIM = 12400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_lat3,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DQM_W-1:0] req_mask,
  input  logic             ref_req,
  output logic             ref_grant,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic [DQM_W-1:0] sd_dqm,
  output logic             sd_wr_oe,
  output logic             rd_capture
);
  localparam int NB = 1 << BA_W;
  localparam int RW = $clog2(T_RRD + 1);

  logic             pend_q, pend_n, pend_wr_q;
  logic [BA_W-1:0]  pend_ba_q;
  logic [ROW_W-1:0] pend_row_q;
  logic [COL_W-1:0] pend_col_q;
  logic [DQM_W-1:0] pend_mask_q;
  logic             accept;

  logic [NB-1:0] b_open, b_col_ok, b_pre_ok, b_act_ok, b_rp_ok, b_due;
  logic [NB-1:0] do_act_v, do_pre_v, do_wr_v;
  logic [ROW_W-1:0] b_row [NB];

  sdr_cmd_e         cmd_d;
  logic [BA_W-1:0]  ba_d, due_ba;
  logic [ROW_W-1:0] addr_d;
  logic             col_fire, due_hit, grant_d;
  logic [RW-1:0]    rrd_q, rrd_n;

  logic [3:0]       pins_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] addr_q;
  logic [DQM_W-1:0] wmask_q, rmask_q, rd_dqm;
  logic             oe_q, rd_q, grant_q;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      sdr_bank_timer #(
        .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_RP(T_RP), .T_WR(T_WR), .T_RAS_LIM(T_RAS_LIM)
      ) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .do_act(do_act_v[g]), .do_pre(do_pre_v[g]), .do_wr(do_wr_v[g]),
        .act_row(addr_d),
        .is_open(b_open[g]), .open_row(b_row[g]),
        .col_ok(b_col_ok[g]), .pre_ok(b_pre_ok[g]), .act_ok(b_act_ok[g]),
        .rp_ok(b_rp_ok[g]), .ras_due(b_due[g])
      );
    end
  endgenerate

  // command choice: refresh close, then aged bank, then pending request
  always_comb begin
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    col_fire = 1'b0;
    due_hit  = 1'b0;
    due_ba   = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (b_due[i] && b_pre_ok[i]) begin
        due_hit = 1'b1;
        due_ba  = BA_W'(i);
      end
    end
    if (ref_req && !pend_q) begin
      if ((|b_open) && ((b_pre_ok | ~b_open) == '1)) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
      end
    end else if (due_hit) begin
      cmd_d = CMD_PRE;
      ba_d  = due_ba;
    end else if (pend_q) begin
      ba_d = pend_ba_q;
      if (b_open[pend_ba_q]) begin
        if (b_row[pend_ba_q] == pend_row_q) begin
          if (b_col_ok[pend_ba_q]) begin
            cmd_d    = pend_wr_q ? CMD_WR : CMD_RD;
            addr_d   = ROW_W'(pend_col_q);
            col_fire = 1'b1;
          end
        end else if (b_pre_ok[pend_ba_q]) begin
          cmd_d = CMD_PRE;
        end
      end else if (b_act_ok[pend_ba_q] && (rrd_q == '0)) begin
        cmd_d  = CMD_ACT;
        addr_d = pend_row_q;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      do_act_v[i] = (cmd_d == CMD_ACT) && (ba_d == BA_W'(i));
      do_wr_v[i]  = (cmd_d == CMD_WR)  && (ba_d == BA_W'(i));
      do_pre_v[i] = (cmd_d == CMD_PRE) && ((ba_d == BA_W'(i)) || addr_d[AP_BIT]);
    end
  end

  assign req_ready = !ref_req && (!pend_q || col_fire);
  assign accept    = req_valid && req_ready;
  assign grant_d   = ref_req && !pend_q && !(|b_open) && (&b_rp_ok);

  always_comb begin
    pend_n = pend_q;
    if (accept)        pend_n = 1'b1;
    else if (col_fire) pend_n = 1'b0;
    rrd_n = (cmd_d == CMD_ACT) ? RW'(T_RRD - 1) :
            (rrd_q != '0)      ? rrd_q - RW'(1) : rrd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_wr_q   <= 1'b0;
      pend_ba_q   <= '0;
      pend_row_q  <= '0;
      pend_col_q  <= '0;
      pend_mask_q <= '0;
      rrd_q       <= '0;
    end else begin
      pend_q <= pend_n;
      rrd_q  <= rrd_n;
      if (accept) begin
        pend_wr_q   <= req_write;
        pend_ba_q   <= req_bank;
        pend_row_q  <= req_row;
        pend_col_q  <= req_col;
        pend_mask_q <= req_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q  <= 4'b0111;
      ba_q    <= '0;
      addr_q  <= '0;
      wmask_q <= '0;
      rmask_q <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      pins_q  <= cmd_pins(cmd_d);
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      wmask_q <= (cmd_d == CMD_WR) ? pend_mask_q : '0;
      rmask_q <= (cmd_d == CMD_RD) ? pend_mask_q : '0;
      oe_q    <= (cmd_d == CMD_WR);
      rd_q    <= (cmd_d == CMD_RD);
      grant_q <= grant_d;
    end
  end

  sdr_rd_align #(.DQM_W(DQM_W)) u_align (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
    .rd_now(rd_q), .rd_mask(rmask_q),
    .capture(rd_capture), .rd_dqm(rd_dqm)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = wmask_q | rd_dqm;
  assign sd_wr_oe  = oe_q;
  assign ref_grant = grant_q;

endmodule

// File: rtl/sdr_bank_engine_chk.sv
module sdr_bank_engine_chk #(
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RC      = 8,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_RAS_LIM = 12400
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cas_lat3,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [BA_W-1:0]  sd_ba,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_wr_oe,
  input logic             rd_capture,
  input logic             ref_grant
);
  localparam int NB   = 1 << BA_W;
  localparam int CAPV = T_RCD + T_RAS + T_RC + T_RRD + T_WR;
  localparam int W    = $clog2(CAPV + 1);
  localparam int LW   = $clog2(T_RAS_LIM + 2);

  logic [3:0] pins;
  logic is_act, is_rd, is_wr, is_pre, is_nop, is_col;
  assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (pins == 4'b0011);
  assign is_rd  = (pins == 4'b0101);
  assign is_wr  = (pins == 4'b0100);
  assign is_pre = (pins == 4'b0010);
  assign is_nop = (pins == 4'b0111);
  assign is_col = is_rd || is_wr;

  logic [W-1:0] any_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      any_q <= W'(CAPV);
    else if (is_act) any_q <= W'(1);
    else if (any_q != W'(CAPV)) any_q <= any_q + W'(1);
  end

  p_rrd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (any_q >= W'(T_RRD)));

  p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (cas_lat3 ? $past(is_rd, 3) : $past(is_rd, 2)));

  p_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sd_wr_oe == is_wr);

  p_grant_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ref_grant |-> is_nop);

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bk
      logic [W-1:0]  act_q, wr_q;
      logic [LW-1:0] age_q;
      logic          open_q, hit_act, hit_wr, hit_pre;
      assign hit_act = is_act && (sd_ba == BA_W'(b));
      assign hit_wr  = is_wr  && (sd_ba == BA_W'(b));
      assign hit_pre = is_pre && ((sd_ba == BA_W'(b)) || sd_addr[AP_BIT]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q  <= W'(CAPV);
          wr_q   <= W'(CAPV);
          age_q  <= '0;
          open_q <= 1'b0;
        end else begin
          if (hit_act) act_q <= W'(1);
          else if (act_q != W'(CAPV)) act_q <= act_q + W'(1);
          if (hit_wr) wr_q <= W'(1);
          else if (wr_q != W'(CAPV)) wr_q <= wr_q + W'(1);
          if (hit_act) age_q <= LW'(1);
          else if (open_q) age_q <= age_q + LW'(1);
          if (hit_act)      open_q <= 1'b1;
          else if (hit_pre) open_q <= 1'b0;
        end
      end

      p_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && sd_ba == BA_W'(b)) |-> (act_q >= W'(T_RCD)));
      p_col_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && sd_ba == BA_W'(b)) |-> open_q);
      p_ras_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pre && open_q) |-> (act_q >= W'(T_RAS)));
      p_rc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_act |-> (act_q >= W'(T_RC)));
      p_wr_rec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pre && open_q) |-> (wr_q >= W'(T_WR)));
      p_ras_max_r13: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (age_q <= LW'(T_RAS_LIM)));
    end
  endgenerate

endmodule

bind sdr_bank_engine sdr_bank_engine_chk #(
  .ROW_W(ROW_W), .BA_W(BA_W), .AP_BIT(AP_BIT), .T_RCD(T_RCD), .T_RAS(T_RAS),
  .T_RC(T_RC), .T_RRD(T_RRD), .T_WR(T_WR), .T_RAS_LIM(T_RAS_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_wr_oe(sd_wr_oe),
  .rd_capture(rd_capture), .ref_grant(ref_grant)
);

// File: tb/sdr_bank_engine_tb_top.sv
`timescale 1ns/1ps
module sdr_bank_engine_tb_top;
  localparam int LIM = 12400;

  logic clk, rst_n, cas_lat3, req_valid, req_ready, req_write, ref_req, ref_grant;
  logic [1:0]  req_bank, sd_ba;
  logic [12:0] req_row, sd_addr;
  logic [9:0]  req_col;
  logic [8:0]  req_mask, sd_dqm;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_wr_oe, rd_capture;

  sdr_bank_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_mask(req_mask),
    .ref_req(ref_req), .ref_grant(ref_grant),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_wr_oe(sd_wr_oe), .rd_capture(rd_capture)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int n_ev, n_cap, n_dq, grant_rise;
  int ev_cmd[64], ev_cyc[64], ev_ba[64], ev_addr[64], ev_dqm[64], ev_oe[64];
  int cap_cyc[16], dq_cyc[16], dq_val[16];
  logic grant_prev = 1'b0;

  // 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRECHARGE, 5 other
  function automatic int dec();
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      4'b0111: return 0;
      4'b0011: return 1;
      4'b0101: return 2;
      4'b0100: return 3;
      4'b0010: return 4;
      default: return 5;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (dec() != 0 && n_ev < 64) begin
        ev_cmd[n_ev] = dec(); ev_cyc[n_ev] = cyc; ev_ba[n_ev] = int'(sd_ba);
        ev_addr[n_ev] = int'(sd_addr); ev_dqm[n_ev] = int'(sd_dqm); ev_oe[n_ev] = int'(sd_wr_oe);
        n_ev++;
      end
      if (rd_capture && n_cap < 16) begin cap_cyc[n_cap] = cyc; n_cap++; end
      if (sd_dqm != '0 && n_dq < 16) begin dq_cyc[n_dq] = cyc; dq_val[n_dq] = int'(sd_dqm); n_dq++; end
      if (ref_grant && !grant_prev) grant_rise = cyc;
      grant_prev = ref_grant;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ev = 0; n_cap = 0; n_dq = 0;
  endtask

  task automatic send(bit w, int ba, int row, int col, int mask);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = 2'(ba);
    req_row = 13'(row); req_col = 10'(col); req_mask = 9'(mask);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int find(int cmd, int ba);
    for (int i = 0; i < n_ev; i++) if (ev_cmd[i] == cmd && ev_ba[i] == ba) return i;
    return 0;
  endfunction

  task automatic t_reset();
    repeat (2) @(negedge clk);
    #1;
    check("R1 nop", dec(), 0);
    check("R1 ready", int'(req_ready), 1);
    check("R1 grant", int'(ref_grant), 0);
    check("R1 capture", int'(rd_capture), 0);
    check("R1 oe", int'(sd_wr_oe), 0);
    check("R1 dqm", int'(sd_dqm), 0);
  endtask

  task automatic t_closed_write();
    clear_log();
    send(1, 0, 5, 9, 0);
    idle(10);
    check("R2 events", n_ev, 2);
    check("R2 act", ev_cmd[0], 1);
    check("R2 row", ev_addr[0], 5);
    check("R2 bank", ev_ba[0], 0);
    check("R2 write", ev_cmd[1], 3);
    check("R2 rcd", ev_cyc[1] - ev_cyc[0], 3);
    check("R2 col addr", ev_addr[1], 9);
    check("R11 oe at write", ev_oe[1], 1);
    check("R11 oe at act", ev_oe[0], 0);
    check("R10 wr dqm zero", ev_dqm[1], 0);
  endtask

  task automatic t_hit_read(bit cl3, int mask);
    cas_lat3 = cl3;
    clear_log();
    send(0, 0, 5, 3, mask);
    idle(10);
    check("R3 hit only read", n_ev, 1);
    check("R3 read cmd", ev_cmd[0], 2);
    check("R9 one capture", n_cap, 1);
    check("R9 latency", cap_cyc[0] - ev_cyc[0], cl3 ? 3 : 2);
    check("R10 rd dqm count", n_dq, 1);
    check("R10 rd dqm lead", dq_cyc[0] - ev_cyc[0], cl3 ? 1 : 0);
    check("R10 rd dqm value", dq_val[0], mask);
  endtask

  task automatic t_back_to_back();
    cas_lat3 = 1'b0;
    clear_log();
    send(0, 0, 5, 1, 0);
    send(0, 0, 5, 2, 0);
    idle(10);
    check("R3 two reads", n_ev, 2);
    check("R3 consecutive", ev_cyc[1] - ev_cyc[0], 1);
    check("R3 second col", ev_addr[1], 2);
    check("R9 two captures", n_cap, 2);
  endtask

  task automatic t_row_miss();
    clear_log();
    send(1, 0, 5, 4, 3);
    send(0, 0, 7, 6, 0);
    idle(20);
    check("R4 events", n_ev, 4);
    check("R10 wr dqm", ev_dqm[0], 3);
    check("R4 pre cmd", ev_cmd[1], 4);
    check("R4 pre single bank", (ev_addr[1] >> 10) & 1, 0);
    check("R8 wr to pre", ev_cyc[1] - ev_cyc[0], 2);
    check("R4 act row", ev_addr[2], 7);
    check("R8 wr to act", ev_cyc[2] - ev_cyc[0], 5);
    check("R4 pre to act", ev_cyc[2] - ev_cyc[1], 3);
    check("R4 act to read", ev_cyc[3] - ev_cyc[2], 3);
  endtask

  task automatic t_tras_min();
    clear_log();
    send(0, 1, 1, 0, 0);
    send(0, 1, 2, 0, 0);
    idle(20);
    check("R5 events", n_ev, 5);
    check("R5 pre cmd", ev_cmd[2], 4);
    check("R5 act to pre", ev_cyc[2] - ev_cyc[0], 6);
    // T_RAS + T_RP = 9 exceeds T_RC = 8
    check("R6 act to act", ev_cyc[3] - ev_cyc[0], 9);
    check("R6 act cmd", ev_cmd[3], 1);
  endtask

  task automatic t_refresh();
    idle(10);
    clear_log();
    @(negedge clk);
    ref_req = 1'b1;
    #1;
    check("R12 ready low", int'(req_ready), 0);
    repeat (25) @(negedge clk);
    check("R12 single pre", n_ev, 1);
    check("R12 pre cmd", ev_cmd[0], 4);
    check("R12 all banks", (ev_addr[0] >> 10) & 1, 1);
    check("R12 grant delay", grant_rise - ev_cyc[0], 3);
    check("R12 granted", int'(ref_grant), 1);
    ref_req = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 grant drop", int'(ref_grant), 0);
    clear_log();
    send(0, 1, 2, 5, 0);
    idle(10);
    check("R12 reopen act", ev_cmd[0], 1);
  endtask

  task automatic t_rrd_age();
    int a2, a3, p2, p3;
    clear_log();
    send(0, 2, 3, 0, 0);
    send(0, 3, 4, 0, 0);
    idle(LIM + 40);
    a2 = find(1, 2); a3 = find(1, 3);
    check("R7 act bank2", ev_cmd[a2] * 10 + ev_ba[a2], 12);
    check("R7 act gap ok", int'(ev_cyc[a3] - ev_cyc[a2] >= 2), 1);
    p2 = find(4, 2); p3 = find(4, 3);
    check("R13 pre bank2", ev_cmd[p2], 4);
    check("R13 bank2 age", ev_cyc[p2] - ev_cyc[a2], LIM);
    check("R13 single bank", (ev_addr[p2] >> 10) & 1, 0);
    check("R13 bank3 age", ev_cyc[p3] - ev_cyc[a3], LIM);
  endtask

  initial begin
    rst_n = 1'b0; cas_lat3 = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; req_mask = '0; ref_req = 1'b0;
    n_ev = 0; n_cap = 0; n_dq = 0; grant_rise = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_closed_write();
        t_hit_read(1'b0, 9'h1FF);
        t_hit_read(1'b1, 9'h0F0);
        t_back_to_back();
        t_row_miss();
        t_tras_min();
        t_refresh();
        t_rrd_age();
      end
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule